// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control section of a microprogrammed processor. It holds a writable control store of 2048 microwords, 41 bits each. It also holds a microinstruction register (MIR) with the word now being executed. On every clock edge where it may advance, it picks the next control-store address. That address is the incremented address, the word's jump target, or an entry address built from the opcode bits of the instruction register. It then loads that word into the MIR. The choice depends on the word's 3-bit condition code, the four ALU flags and instruction bit 13.

The MIR is broken into datapath controls: three 6-bit register selects, the memory read and write strobes, and a 4-bit ALU function. When a select's substitution bit is set, the select is taken from the matching instruction field instead of the microword. A word that asserts a memory strobe is held until memory acknowledges. The control store is loaded through a write port. Reads are synchronous and form the MIR.

Top module: `mseq_top`

## Requirements
- R1: While reset is active, `upc` is 0 and all MIR-driven outputs are 0. On the first clock edge after reset is released, the MIR loads the word at address 0 and `upc` stays 0.
- R2: Microword bits, numbered from bit 40 down, are: A select [40:35], A substitute [34], B select [33:28], B substitute [27], C select [26:21], C substitute [20], read [19], write [18], ALU function [17:14], condition [13:11], jump address [10:0]. `mem_rd`, `mem_wr` and `alu_op` show those bits of the word in the MIR.
- R3: When a substitute bit is set, its select becomes {0, instruction field}. The fields are A = ir[18:14], B = ir[4:0] and C = ir[29:25]. When the bit is clear, the select is the microword field.
- R4: Condition 000 goes to `upc`+1, and the address wraps from 2047 to 0.
- R5: Conditions 001, 010, 011 and 100 go to the jump address when flag n, z, v or c (flags[3], [2], [1], [0]) is 1. Otherwise they go to `upc`+1.
- R6: Condition 101 goes to the jump address when ir[13] is 1. Otherwise it goes to `upc`+1.
- R7: Condition 110 always goes to the jump address.
- R8: Condition 111 goes to {1, ir[31:30], ir[24:19], 00}. For example, ir[31:30]=10 with ir[24:19]=010000 gives 1600.
- R9: `addr_src` shows the current choice: 00 incremented, 01 jump, 10 decode. It never shows 11.
- R10: While the MIR word has the read or write bit set and `mem_ack` is 0, `upc` and the MIR hold. An edge with `mem_ack`=1 lets the block advance.
- R11: A write to the control store takes effect for any later load of that address. A load in the same cycle as the write returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 11 | Control-store write address |
| cs_wdata | input | 41 | Control-store write data |
| ir | input | 32 | Instruction register contents |
| flags | input | 4 | {n, z, v, c} |
| mem_ack | input | 1 | Memory acknowledge |
| upc | output | 11 | Address of the word in the MIR |
| addr_src | output | 2 | Next-address choice (00/01/10) |
| a_sel | output | 6 | A register select |
| b_sel | output | 6 | B register select |
| c_sel | output | 6 | C register select |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| alu_op | output | 4 | ALU function |

## Verification
The bench targets five cases:
- The first edge after reset. A design that ran the increment rule from an empty MIR would start executing at address 1.
- The wrap from 2047 to 0. A design that carried into a wider counter would leave the store.
- The decode address, where swapped or shifted opcode fields would send an instruction to the wrong routine.
- A stall held over several cycles with the acknowledge arriving late. A sequencer that ignored the strobe would skip words or repeat memory accesses.
- A store rewrite during a stall, which shows whether later loads see the new word.

Random microprograms and random flags, instructions and acknowledges are compared every cycle with a behavioural model. This covers every condition code, both values of each substitute bit, and writes in the same cycle as loads.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int UA_W   = 11;
    localparam int SEL_W  = 6;
    localparam int IRF_W  = 5;
    localparam int ALU_W  = 4;
    localparam int FLAG_W = 4;
    localparam int IR_W   = 32;

    typedef enum logic [2:0] {
        C_SEQ    = 3'b000,
        C_NEG    = 3'b001,
        C_ZERO   = 3'b010,
        C_OVF    = 3'b011,
        C_CARRY  = 3'b100,
        C_IR13   = 3'b101,
        C_ALWAYS = 3'b110,
        C_DECODE = 3'b111
    } cond_e;

    typedef enum logic [1:0] {
        SRC_NEXT   = 2'b00,
        SRC_JUMP   = 2'b01,
        SRC_DECODE = 2'b10
    } src_e;

    typedef struct packed {
        logic [SEL_W-1:0] a_fld;
        logic             a_sub;
        logic [SEL_W-1:0] b_fld;
        logic             b_sub;
        logic [SEL_W-1:0] c_fld;
        logic             c_sub;
        logic             rd;
        logic             wr;
        logic [ALU_W-1:0] alu;
        cond_e            cond;
        logic [UA_W-1:0]  jaddr;
    } uword_t;

    localparam int UW_W = $bits(uword_t);

    typedef struct packed {
        logic            boot;
        logic [UA_W-1:0] upc;
    } seq_t;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
    parameter int AW = 11,
    parameter int DW = 41
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // old contents on a same-cycle write: nonblocking update lands after the read
    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  cond_e             cond,
    input  logic [UA_W-1:0]   jaddr,
    input  logic [UA_W-1:0]   upc,
    input  logic [FLAG_W-1:0] flags,
    input  logic [1:0]        ir_op,
    input  logic [5:0]        ir_op3,
    input  logic              ir_imm,
    output logic [1:0]        src,
    output logic [UA_W-1:0]   nxt
);
    localparam int DEC_W = 1 + 2 + 6 + 2;
    localparam int PAD_W = UA_W - DEC_W;

    logic            take;
    logic [UA_W-1:0] dec_addr;
    logic [UA_W-1:0] inc_addr;

    generate
        if (PAD_W > 0) begin : g_pad
            assign dec_addr = {{PAD_W{1'b0}}, 1'b1, ir_op, ir_op3, 2'b00};
        end else begin : g_nopad
            assign dec_addr = {1'b1, ir_op, ir_op3, 2'b00};
        end
    endgenerate

    assign inc_addr = upc + 1'b1;

    always_comb begin
        take = 1'b0;
        unique case (cond)
            C_SEQ:    take = 1'b0;
            C_NEG:    take = flags[3];
            C_ZERO:   take = flags[2];
            C_OVF:    take = flags[1];
            C_CARRY:  take = flags[0];
            C_IR13:   take = ir_imm;
            C_ALWAYS: take = 1'b1;
            C_DECODE: take = 1'b0;
            default:  take = 1'b0;
        endcase
    end

    always_comb begin
        if (cond == C_DECODE) begin
            src = SRC_DECODE;
            nxt = dec_addr;
        end else if (take) begin
            src = SRC_JUMP;
            nxt = jaddr;
        end else begin
            src = SRC_NEXT;
            nxt = inc_addr;
        end
    end
endmodule

// File: rtl/mseq_fields.sv
module mseq_fields
    import mseq_pkg::*;
(
    input  uword_t           mw,
    input  logic [IR_W-1:0]  ir,
    output logic [SEL_W-1:0] a_sel,
    output logic [SEL_W-1:0] b_sel,
    output logic [SEL_W-1:0] c_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [ALU_W-1:0] alu_op
);
    localparam int NSEL = 3;

    logic [SEL_W-1:0] fld  [NSEL];
    logic             sub  [NSEL];
    logic [IRF_W-1:0] irf  [NSEL];
    logic [SEL_W-1:0] sel  [NSEL];

    assign fld[0] = mw.a_fld;  assign sub[0] = mw.a_sub;  assign irf[0] = ir[18:14];
    assign fld[1] = mw.b_fld;  assign sub[1] = mw.b_sub;  assign irf[1] = ir[4:0];
    assign fld[2] = mw.c_fld;  assign sub[2] = mw.c_sub;  assign irf[2] = ir[29:25];

    generate
        for (genvar k = 0; k < NSEL; k++) begin : g_sel
            assign sel[k] = sub[k] ? SEL_W'(irf[k]) : fld[k];
        end
    endgenerate

    assign a_sel  = sel[0];
    assign b_sel  = sel[1];
    assign c_sel  = sel[2];
    assign mem_rd = mw.rd;
    assign mem_wr = mw.wr;
    assign alu_op = mw.alu;

    logic unused_ir;
    assign unused_ir = ^{ir[31:30], ir[24:19], ir[13:5]};
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_we,
    input  logic [UA_W-1:0]   cs_waddr,
    input  logic [UW_W-1:0]   cs_wdata,
    input  logic [IR_W-1:0]   ir,
    input  logic [FLAG_W-1:0] flags,
    input  logic              mem_ack,
    output logic [UA_W-1:0]   upc,
    output logic [1:0]        addr_src,
    output logic [SEL_W-1:0]  a_sel,
    output logic [SEL_W-1:0]  b_sel,
    output logic [SEL_W-1:0]  c_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ALU_W-1:0]  alu_op
);
    seq_t            seq_d, seq_q;
    logic [UW_W-1:0] mir_raw;
    uword_t          mw;
    logic [UA_W-1:0] nxt;
    logic            advance;

    assign mw = uword_t'(mir_raw);

    mseq_next u_next (
        .cond   (mw.cond),
        .jaddr  (mw.jaddr),
        .upc    (seq_q.upc),
        .flags  (flags),
        .ir_op  (ir[31:30]),
        .ir_op3 (ir[24:19]),
        .ir_imm (ir[13]),
        .src    (addr_src),
        .nxt    (nxt)
    );

    assign advance = seq_q.boot | ~(mw.rd | mw.wr) | mem_ack;

    always_comb begin
        seq_d = seq_q;
        if (advance) begin
            seq_d.boot = 1'b0;
            seq_d.upc  = seq_q.boot ? '0 : nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{boot: 1'b1, upc: '0};
        else        seq_q <= seq_d;
    end

    mseq_store #(.AW(UA_W), .DW(UW_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .re    (advance),
        .raddr (seq_d.upc),
        .rdata (mir_raw)
    );

    mseq_fields u_fields (
        .mw     (mw),
        .ir     (ir),
        .a_sel  (a_sel),
        .b_sel  (b_sel),
        .c_sel  (c_sel),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .alu_op (alu_op)
    );

    assign upc = seq_q.upc;

    // R1
    boot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.boot |=> (upc == '0));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.boot && (mem_rd || mem_wr) && !mem_ack) |=> $stable(upc));

    // R4
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.boot && advance && addr_src == SRC_NEXT) |=> (upc == UA_W'($past(upc) + 1'b1)));

    // R8
    decode_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.boot && advance && addr_src == SRC_DECODE) |=> (upc[10] && upc[1:0] == 2'b00));

    // R7
    jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.boot && advance && mw.cond == C_ALWAYS) |=> (upc == $past(mw.jaddr)));

    // R9
    src_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_src != 2'b11);
endmodule

// File: tb/tb_mseq_top.sv
`timescale 1ns/1ps
module tb_mseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_we = 1'b0;
    logic [10:0] cs_waddr = '0;
    logic [40:0] cs_wdata = '0;
    logic [31:0] ir = '0;
    logic [3:0]  flags = '0;
    logic        mem_ack = 1'b0;
    logic [10:0] upc;
    logic [1:0]  addr_src;
    logic [5:0]  a_sel, b_sel, c_sel;
    logic        mem_rd, mem_wr;
    logic [3:0]  alu_op;

    always #2.5 clk = ~clk;

    mseq_top dut (
        .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr),
        .cs_wdata(cs_wdata), .ir(ir), .flags(flags), .mem_ack(mem_ack),
        .upc(upc), .addr_src(addr_src), .a_sel(a_sel), .b_sel(b_sel),
        .c_sel(c_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_op(alu_op)
    );

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [40:0] m_cs [2048];
    logic [40:0] m_mir = '0;
    int          m_upc = 0;
    bit          m_boot = 1'b1;
    string       m_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [40:0] mk(input logic [5:0] a, input logic am,
        input logic [5:0] b, input logic bm, input logic [5:0] c, input logic cm,
        input logic r, input logic w, input logic [3:0] alu, input logic [2:0] cond,
        input logic [10:0] j);
        return {a, am, b, bm, c, cm, r, w, alu, cond, j};
    endfunction

    function automatic logic [1:0] f_src(input logic [40:0] w, input logic [3:0] fl,
                                         input logic i13);
        case (w[13:11])
            3'd0: return 2'b00;
            3'd1: return fl[3] ? 2'b01 : 2'b00;
            3'd2: return fl[2] ? 2'b01 : 2'b00;
            3'd3: return fl[1] ? 2'b01 : 2'b00;
            3'd4: return fl[0] ? 2'b01 : 2'b00;
            3'd5: return i13 ? 2'b01 : 2'b00;
            3'd6: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R4";
            3'd5: return "R6";
            3'd6: return "R7";
            3'd7: return "R8";
            default: return "R5";
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        logic [40:0] word;
        int          tgt;
        bit          adv;
        logic [1:0]  s;
        if (!rst_n) begin
            m_upc = 0; m_boot = 1'b1; m_mir = '0; m_tag = "R1";
        end else begin
            adv = m_boot || !(m_mir[19] || m_mir[18]) || mem_ack;
            if (adv) begin
                if (m_boot) begin
                    tgt = 0; m_tag = "R1";
                end else begin
                    s = f_src(m_mir, flags, ir[13]);
                    m_tag = tag_of(m_mir[13:11]);
                    if (s == 2'b00)      tgt = (m_upc + 1) % 2048;
                    else if (s == 2'b01) tgt = int'(m_mir[10:0]);
                    else                 tgt = 1024 + int'(ir[31:30]) * 256 + int'(ir[24:19]) * 4;
                end
                word   = m_cs[tgt];
                m_mir  = word;
                m_upc  = tgt;
                m_boot = 1'b0;
            end else begin
                m_tag = "R10";
            end
        end
        if (cs_we) m_cs[cs_waddr] = cs_wdata;
    end

    // compare every cycle, away from the edge and before new inputs are driven
    always @(negedge clk) begin
        logic [5:0] ea, eb, ec;
        ea = m_mir[34] ? {1'b0, ir[18:14]} : m_mir[40:35];
        eb = m_mir[27] ? {1'b0, ir[4:0]}   : m_mir[33:28];
        ec = m_mir[20] ? {1'b0, ir[29:25]} : m_mir[26:21];
        chk(upc == m_upc[10:0], m_tag, "upc", 64'(upc), 64'(m_upc));
        chk(addr_src == f_src(m_mir, flags, ir[13]), "R9", "addr_src",
            64'(addr_src), 64'(f_src(m_mir, flags, ir[13])));
        chk({a_sel, b_sel, c_sel} == {ea, eb, ec}, "R3", "selects",
            64'({a_sel, b_sel, c_sel}), 64'({ea, eb, ec}));
        chk({mem_rd, mem_wr, alu_op} == {m_mir[19], m_mir[18], m_mir[17:14]}, "R2",
            "rd/wr/alu", 64'({mem_rd, mem_wr, alu_op}), 64'({m_mir[19], m_mir[18], m_mir[17:14]}));
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wr_cs(input int a, input logic [40:0] d);
        cs_we = 1'b1; cs_waddr = 11'(a); cs_wdata = d;
        step();
        cs_we = 1'b0;
    endtask

    localparam logic [31:0] IR_D = {2'b10, 5'd7, 6'b010000, 5'd3, 1'b1, 8'd0, 5'd9};

    initial begin
        // R11: whole store loaded through the write port during reset
        #1;
        for (int i = 0; i < 2048; i++) wr_cs(i, {$urandom, $urandom});
        rst_n = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            step();
            ir      = $urandom;
            flags   = 4'($urandom);
            mem_ack = ($urandom % 3) != 0;
            if (($urandom % 16) == 0) begin
                cs_we = 1'b1; cs_waddr = 11'($urandom); cs_wdata = {$urandom, $urandom};
            end else begin
                cs_we = 1'b0;
            end
        end
        cs_we = 1'b0;

        // directed phase
        rst_n = 1'b0; mem_ack = 1'b0; flags = '0; ir = IR_D;
        step(); step();
        wr_cs(0,    mk(0, 0, 0, 0, 0, 0, 0, 0, 4'h0, 3'b111, 11'd0));
        wr_cs(1600, mk(6'd40, 1, 6'd41, 1, 6'd42, 1, 0, 0, 4'hA, 3'b101, 11'd1234));
        wr_cs(1234, mk(0, 0, 0, 0, 0, 0, 1, 0, 4'h3, 3'b110, 11'd2047));
        wr_cs(2047, mk(6'd5, 0, 6'd6, 0, 6'd7, 0, 0, 0, 4'h1, 3'b000, 11'd0));
        wr_cs(77,   mk(0, 0, 0, 0, 0, 0, 0, 0, 4'h2, 3'b110, 11'd77));
        // R1: reset state
        chk(upc == 0 && !mem_rd && !mem_wr, "R1", "reset outputs", 64'({upc, mem_rd, mem_wr}), 64'(0));
        rst_n = 1'b1;
        step();
        chk(upc == 0, "R1", "first load at address 0", 64'(upc), 64'(0));
        chk(addr_src == 2'b10, "R9", "decode source code", 64'(addr_src), 64'(2));
        step();
        chk(upc == 11'd1600, "R8", "decode address", 64'(upc), 64'(1600));
        chk(a_sel == 6'd3 && b_sel == 6'd9 && c_sel == 6'd7, "R3", "substituted selects",
            64'({a_sel, b_sel, c_sel}), 64'({6'd3, 6'd9, 6'd7}));
        chk(alu_op == 4'hA, "R2", "alu field", 64'(alu_op), 64'(4'hA));
        chk(addr_src == 2'b01, "R6", "ir13 jump taken", 64'(addr_src), 64'(1));
        step();
        chk(upc == 11'd1234 && mem_rd, "R2", "read strobe word", 64'({upc, mem_rd}), 64'({11'd1234, 1'b1}));
        step(); step();
        chk(upc == 11'd1234, "R10", "held without ack", 64'(upc), 64'(1234));
        wr_cs(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 4'h0, 3'b011, 11'd77));
        chk(upc == 11'd1234, "R10", "still held", 64'(upc), 64'(1234));
        mem_ack = 1'b1;
        step();
        chk(upc == 11'd2047, "R7", "unconditional jump after ack", 64'(upc), 64'(2047));
        mem_ack = 1'b0; flags = 4'b0010;
        step();
        chk(upc == 11'd0, "R4", "wrap 2047 to 0", 64'(upc), 64'(0));
        step();
        chk(upc == 11'd77, "R5", "overflow-flag jump via rewritten word (R11)", 64'(upc), 64'(77));
        step();
        finish_run();
    end
endmodule